// File: doc/BRIEF.md
# Timestamped Receive Burst Framer

The framer sits between a live stream of receive I/Q samples and a host-bound packet stream. A short command, sent on its own stream, tells it how many samples to collect and, optionally, the exact sample time at which to begin. The framer then emits one packet per burst. The packet opens with a header beat that echoes the command and carries status bits. Two beats follow with the 64-bit time of the first captured sample, and then the payload words. With this a host can ask for bursts that line up exactly with the sample time base.

The time base counts every sample beat accepted on the sample input, whether that sample is captured or dropped, so a timestamp names the sample's position in the stream. At packet start the framer briefly holds off the sample stream while it sends the three framing beats. During the payload it takes every sample. If the output is still blocked when a sample arrives, the burst is cut short and the next header reports it. A runtime select chooses between one full 16-bit I/Q sample per word and two 8-bit I/Q samples per word. A continuous mode keeps producing packets of the commanded size until another command arrives.

Top module: `rx_burst_framer`

## Requirements
- R1: After reset the packet output is not valid, and both the command input and the sample input are ready.
- R2: A command takes three beats on the command stream. Beat 0 holds the sample count in bits 15:0, the wait-for-time flag in bit 16 and the continuous flag in bit 17. Beat 1 holds start time bits 63:32 and beat 2 holds start time bits 31:0. A command with count zero is consumed, produces no packet, and ends continuous mode.
- R3: Each packet is one header beat, then timestamp bits 63:32, then timestamp bits 31:0, then the payload words, with tlast high only on the final payload word. The header holds the count in bits 15:0, the wait flag in bit 16, the continuous flag in bit 17, late in bit 18, overflow in bit 19 and narrow mode in bit 20. All other header bits are zero.
- R4: The time base increments once per accepted sample beat and never otherwise. The timestamp equals the time of the first captured sample. In wide mode, payload word k is the input sample taken at timestamp+k, unchanged.
- R5: With the wait flag set and a start time ahead of the time base, samples are accepted and dropped until the time base reaches the start time. The timestamp then equals the start time exactly, and late is 0.
- R6: With the wait flag set and a start time already passed, capture begins at once and the header late bit is 1.
- R7: In narrow mode (select high when the header is sent), each sample is reduced to {I[15:8], Q[15:8]}, taken from input bits 31:24 and 15:8. Two such pairs fill a word, with the earlier sample in bits 15:0. An odd count leaves the final word's bits 31:16 zero.
- R8: The sample input is not ready while framing beats are pending. In the payload phase it is always ready.
- R9: A sample that arrives in the payload phase while the output word slot is still occupied is dropped. The packet is then closed with an all-zero beat with tlast high, and the next header has the overflow bit set. The bit is cleared again in the header after that.
- R10: In continuous mode, packets of the commanded size follow back to back. Each timestamp equals the previous one plus the count. Any newly received command ends the run at the next packet boundary.
- R11: While the output is valid and not accepted, its data and tlast hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_sel | input | 1 | 1 selects two 8-bit I/Q samples per output word |
| cmd_tdata | input | 32 | Command beat |
| cmd_tvalid | input | 1 | Command beat valid |
| cmd_tready | output | 1 | Command beat accepted |
| smp_tdata | input | 32 | Sample, I in bits 31:16, Q in bits 15:0 |
| smp_tvalid | input | 1 | Sample valid |
| smp_tready | output | 1 | Sample accepted |
| pkt_tdata | output | 32 | Packet word |
| pkt_tvalid | output | 1 | Packet word valid |
| pkt_tready | input | 1 | Packet word accepted downstream |
| pkt_tlast | output | 1 | Final word of a packet |

## Verification
The hardest situation to reach is an overflow: the output slot must still be occupied in the exact cycle a payload sample arrives, after the framing beats have already drained. The bench reaches it by waiting until it has collected the third framing beat and then dropping pkt_tready for a few cycles while samples keep arriving. It then checks that the packet closes with a zero tlast beat and that the next two headers show the overflow bit set and then cleared. Every payload sample carries its own stream index, so a timestamp that is off by one sample shows up directly in the payload comparison.

// File: rtl/rbf_pkg.sv
// Package: shared constants, command record, state encoding and helpers
// for the receive burst framer. Assumes the fixed 32-bit beat layout.
package rbf_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 16;
    localparam int TIME_W  = 64;
    localparam int PAIR_W  = 16;
    localparam int CMD_BEATS = 3;
    localparam int BEAT_IDX_W = $clog2(CMD_BEATS);

    // Field positions inside command beat 0 and the packet header
    localparam int F_WAIT   = 16;
    localparam int F_CONT   = 17;
    localparam int F_LATE   = 18;
    localparam int F_OVF    = 19;
    localparam int F_NARROW = 20;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic              wait_time;
        logic              cont;
        logic [TIME_W-1:0] start;
    } burst_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HDR,
        ST_PAY,
        ST_CLOSE
    } rbf_state_e;

    // Assemble the header beat from the command echo and status bits
    function automatic logic [WORD_W-1:0] make_header(
        input burst_cmd_t c, input logic late, input logic ovf, input logic narrow);
        logic [WORD_W-1:0] h;
        h = '0;
        h[CNT_W-1:0] = c.count;
        h[F_WAIT]    = c.wait_time;
        h[F_CONT]    = c.cont;
        h[F_LATE]    = late;
        h[F_OVF]     = ovf;
        h[F_NARROW]  = narrow;
        return h;
    endfunction

    // Reduce a 16-bit I/Q sample to its 8-bit I/Q pair
    function automatic logic [PAIR_W-1:0] to_pair(input logic [WORD_W-1:0] s);
        return {s[31:24], s[15:8]};
    endfunction
endpackage

// File: rtl/rbf_cmd_parser.sv
// Command collector: gathers the three command beats into one record and
// holds it until the controller takes it. Assumes the controller asserts
// take only while pending is high.
module rbf_cmd_parser
    import rbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_tdata,
    input  logic              cmd_tvalid,
    output logic              cmd_tready,
    input  logic              take,
    output logic              pending,
    output burst_cmd_t        cmd
);
    logic [BEAT_IDX_W-1:0] beat_q;
    logic                  fire;

    assign cmd_tready = !pending;
    assign fire       = cmd_tvalid && cmd_tready;

    // Collect beats in order and raise pending on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= '0;
            pending <= 1'b0;
            cmd     <= '0;
        end else begin
            if (take) pending <= 1'b0;
            if (fire) begin
                case (beat_q)
                    BEAT_IDX_W'(0): begin
                        cmd.count     <= cmd_tdata[CNT_W-1:0];
                        cmd.wait_time <= cmd_tdata[F_WAIT];
                        cmd.cont      <= cmd_tdata[F_CONT];
                        beat_q        <= BEAT_IDX_W'(1);
                    end
                    BEAT_IDX_W'(1): begin
                        cmd.start[TIME_W-1:WORD_W] <= cmd_tdata;
                        beat_q                     <= BEAT_IDX_W'(2);
                    end
                    default: begin
                        cmd.start[WORD_W-1:0] <= cmd_tdata;
                        beat_q                <= '0;
                        pending               <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rbf_time_base.sv
// Sample time base: counts accepted sample beats. Assumes tick is one
// per accepted sample; wraps at 2^W.
module rbf_time_base #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] now
);
    // Advance one step per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)    now <= '0;
        else if (tick) now <= now + W'(1);
    end
endmodule

// File: rtl/rbf_burst_ctrl.sv
// Burst controller: takes commands, waits for the start time, sends the
// header and timestamp beats, packs payload samples into the one-word
// output slot and handles overflow and continuous runs. Assumes the time
// base advances exactly on smp_tvalid && smp_tready.
module rbf_burst_ctrl
    import rbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_sel,
    input  burst_cmd_t        cmd,
    input  logic              cmd_pending,
    output logic              cmd_take,
    input  logic [TIME_W-1:0] now,
    input  logic [WORD_W-1:0] smp_tdata,
    input  logic              smp_tvalid,
    output logic              smp_tready,
    output logic [WORD_W-1:0] pkt_tdata,
    output logic              pkt_tvalid,
    input  logic              pkt_tready,
    output logic              pkt_tlast,
    output logic              waiting,
    output logic [TIME_W-1:0] arm_start
);
    rbf_state_e        state;
    burst_cmd_t        cur;
    logic [1:0]        hidx;
    logic              late_q, ovf_q, narrow_q, half_q;
    logic [TIME_W-1:0] ts_q;
    logic [CNT_W-1:0]  rem;
    logic [PAIR_W-1:0] pack_q;
    logic              slot_free, smp_fire, last_smp, need_load;
    logic [PAIR_W-1:0] pair;

    assign slot_free = !pkt_tvalid || pkt_tready;
    assign smp_fire  = smp_tvalid && smp_tready;
    assign pair      = to_pair(smp_tdata);
    assign last_smp  = (rem == CNT_W'(1));
    assign need_load = !narrow_q || half_q || last_smp;
    assign cmd_take  = (state == ST_IDLE) && cmd_pending;
    assign waiting   = (state == ST_WAIT);
    assign arm_start = cur.start;

    // Sample acceptance: free-flow except while framing or deciding
    always_comb begin
        case (state)
            ST_IDLE: smp_tready = !cmd_pending;
            ST_WAIT: smp_tready = (now != cur.start);
            ST_PAY:  smp_tready = 1'b1;
            default: smp_tready = 1'b0;
        endcase
    end

    // Burst sequencing and output slot loading
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur        <= '0;
            hidx       <= '0;
            late_q     <= 1'b0;
            ovf_q      <= 1'b0;
            narrow_q   <= 1'b0;
            half_q     <= 1'b0;
            ts_q       <= '0;
            rem        <= '0;
            pack_q     <= '0;
            pkt_tdata  <= '0;
            pkt_tvalid <= 1'b0;
            pkt_tlast  <= 1'b0;
        end else begin
            if (pkt_tvalid && pkt_tready) pkt_tvalid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_pending && cmd.count != '0) begin
                        cur  <= cmd;
                        hidx <= '0;
                        if (cmd.wait_time && cmd.start > now) begin
                            state <= ST_WAIT;
                        end else begin
                            ts_q   <= now;
                            late_q <= cmd.wait_time && (cmd.start < now);
                            state  <= ST_HDR;
                        end
                    end
                end
                ST_WAIT: begin
                    if (now == cur.start) begin
                        ts_q   <= now;
                        late_q <= 1'b0;
                        state  <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (slot_free) begin
                        pkt_tvalid <= 1'b1;
                        pkt_tlast  <= 1'b0;
                        case (hidx)
                            2'd0: begin
                                pkt_tdata <= make_header(cur, late_q, ovf_q, narrow_sel);
                                ovf_q     <= 1'b0;
                                narrow_q  <= narrow_sel;
                                hidx      <= 2'd1;
                            end
                            2'd1: begin
                                pkt_tdata <= ts_q[TIME_W-1:WORD_W];
                                hidx      <= 2'd2;
                            end
                            default: begin
                                pkt_tdata <= ts_q[WORD_W-1:0];
                                rem       <= cur.count;
                                half_q    <= 1'b0;
                                state     <= ST_PAY;
                            end
                        endcase
                    end
                end
                ST_PAY: begin
                    if (smp_fire) begin
                        if (need_load && !slot_free) begin
                            ovf_q <= 1'b1;
                            state <= ST_CLOSE;
                        end else begin
                            rem <= rem - CNT_W'(1);
                            if (need_load) begin
                                pkt_tvalid <= 1'b1;
                                pkt_tlast  <= last_smp;
                                half_q     <= 1'b0;
                                if (!narrow_q)   pkt_tdata <= smp_tdata;
                                else if (half_q) pkt_tdata <= {pair, pack_q};
                                else             pkt_tdata <= {{PAIR_W{1'b0}}, pair};
                            end else begin
                                pack_q <= pair;
                                half_q <= 1'b1;
                            end
                            if (last_smp) begin
                                if (cur.cont && !cmd_pending) begin
                                    ts_q   <= now + TIME_W'(1);
                                    late_q <= 1'b0;
                                    hidx   <= '0;
                                    state  <= ST_HDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        end
                    end
                end
                ST_CLOSE: begin
                    if (slot_free) begin
                        pkt_tvalid <= 1'b1;
                        pkt_tlast  <= 1'b1;
                        pkt_tdata  <= '0;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_burst_framer.sv
// Top: receive burst framer. Wires the command collector, the sample
// time base and the burst controller. Assumes one clock domain.
module rx_burst_framer
    import rbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_sel,
    input  logic [WORD_W-1:0] cmd_tdata,
    input  logic              cmd_tvalid,
    output logic              cmd_tready,
    input  logic [WORD_W-1:0] smp_tdata,
    input  logic              smp_tvalid,
    output logic              smp_tready,
    output logic [WORD_W-1:0] pkt_tdata,
    output logic              pkt_tvalid,
    input  logic              pkt_tready,
    output logic              pkt_tlast
);
    burst_cmd_t        cmd_q;
    logic              cmd_pending, cmd_take, ctrl_waiting;
    logic [TIME_W-1:0] time_now, arm_start;

    rbf_cmd_parser u_parser (
        .clk(clk), .rst_n(rst_n),
        .cmd_tdata(cmd_tdata), .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready),
        .take(cmd_take), .pending(cmd_pending), .cmd(cmd_q)
    );

    rbf_time_base #(.W(TIME_W)) u_time (
        .clk(clk), .rst_n(rst_n),
        .tick(smp_tvalid && smp_tready), .now(time_now)
    );

    rbf_burst_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .narrow_sel(narrow_sel),
        .cmd(cmd_q), .cmd_pending(cmd_pending), .cmd_take(cmd_take),
        .now(time_now),
        .smp_tdata(smp_tdata), .smp_tvalid(smp_tvalid), .smp_tready(smp_tready),
        .pkt_tdata(pkt_tdata), .pkt_tvalid(pkt_tvalid), .pkt_tready(pkt_tready),
        .pkt_tlast(pkt_tlast),
        .waiting(ctrl_waiting), .arm_start(arm_start)
    );
endmodule

// File: rtl/rbf_checker.sv
// Checker: protocol and time-base properties of the framer, bound to the
// top module. Assumes synchronous active-low reset.
module rbf_checker
    import rbf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              smp_tvalid,
    input logic              smp_tready,
    input logic [WORD_W-1:0] pkt_tdata,
    input logic              pkt_tvalid,
    input logic              pkt_tready,
    input logic              pkt_tlast,
    input logic [TIME_W-1:0] time_now,
    input logic              cmd_pending,
    input logic              cmd_take,
    input logic              ctrl_waiting,
    input logic [TIME_W-1:0] arm_start
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_tvalid && !pkt_tready |=> pkt_tvalid && $stable(pkt_tdata) && $stable(pkt_tlast)); // R11
    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tvalid && smp_tready |=> time_now == $past(time_now) + TIME_W'(1)); // R4
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_tvalid && smp_tready) |=> $stable(time_now)); // R4
    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_take |-> cmd_pending); // R2
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_waiting |-> time_now <= arm_start); // R5
endmodule

bind rx_burst_framer rbf_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .smp_tvalid(smp_tvalid), .smp_tready(smp_tready),
    .pkt_tdata(pkt_tdata), .pkt_tvalid(pkt_tvalid), .pkt_tready(pkt_tready),
    .pkt_tlast(pkt_tlast),
    .time_now(time_now), .cmd_pending(cmd_pending), .cmd_take(cmd_take),
    .ctrl_waiting(ctrl_waiting), .arm_start(arm_start)
);

// File: tb/rx_burst_framer_tb.sv
// Directed bench: one task per scenario; samples carry their own stream index.
module rx_burst_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_sel = 1'b0;
    logic [31:0] cmd_tdata = '0;
    logic        cmd_tvalid = 1'b0;
    logic        cmd_tready;
    logic [31:0] smp_tdata;
    logic        smp_tvalid = 1'b0;
    logic        smp_tready;
    logic [31:0] pkt_tdata;
    logic        pkt_tvalid;
    logic        pkt_tready = 1'b1;
    logic        pkt_tlast;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] tidx = '0;
    logic        gap_on = 1'b0;
    logic [7:0]  lfsr = 8'h5B;
    logic [31:0] bq_data [0:4095];
    logic        bq_last [0:4095];
    int bq_n = 0;
    int rd = 0;

    always #2 clk = ~clk;   // 250 MHz

    rx_burst_framer u_dut (
        .clk(clk), .rst_n(rst_n), .narrow_sel(narrow_sel),
        .cmd_tdata(cmd_tdata), .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready),
        .smp_tdata(smp_tdata), .smp_tvalid(smp_tvalid), .smp_tready(smp_tready),
        .pkt_tdata(pkt_tdata), .pkt_tvalid(pkt_tvalid), .pkt_tready(pkt_tready),
        .pkt_tlast(pkt_tlast)
    );

    function automatic logic [31:0] mk(input logic [63:0] i);
        return {i[15:0], i[15:0] ^ 16'hA5C3};
    endfunction
    function automatic logic [15:0] pr(input logic [63:0] i);
        logic [31:0] w;
        w = mk(i);
        return {w[31:24], w[15:8]};
    endfunction

    assign smp_tdata = mk(tidx);

    // Sample source bookkeeping: index advances on each handshake
    always @(posedge clk) if (rst_n && smp_tvalid && smp_tready) tidx <= tidx + 64'd1;

    // Sample valid driver, optionally gappy
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        smp_tvalid = rst_n && (!gap_on || lfsr[0]);
    end

    // Output collector
    always @(negedge clk) begin
        if (pkt_tvalid && pkt_tready) begin
            bq_data[bq_n] = pkt_tdata;
            bq_last[bq_n] = pkt_tlast;
            bq_n++;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic get_beat(output logic [31:0] d, output logic l);
        int t;
        t = 0;
        while (bq_n <= rd && t < 3000) begin @(negedge clk); t++; end
        if (bq_n <= rd) begin
            chk(1'b0, "R3 beat timeout", 0, 1);
            d = '0; l = 1'b1;
        end else begin
            d = bq_data[rd]; l = bq_last[rd]; rd++;
        end
    endtask

    task automatic send_cmd(input logic [15:0] cnt, input logic wt, input logic ct, input logic [63:0] st);
        for (int b = 0; b < 3; b++) begin
            @(posedge clk); #1;
            cmd_tvalid = 1'b1;
            cmd_tdata  = (b == 0) ? {14'b0, ct, wt, cnt} : (b == 1) ? st[63:32] : st[31:0];
            do @(negedge clk); while (!cmd_tready);
        end
        @(posedge clk); #1;
        cmd_tvalid = 1'b0;
    endtask

    // Read one packet, check payload against timestamp-derived samples
    task automatic read_pkt(input string tag, input logic chk_pay,
                            output logic [31:0] hdr, output logic [63:0] ts, output int nw);
        logic [31:0] d;
        logic        l;
        logic [31:0] e;
        int cnt, exp_w;
        get_beat(hdr, l);
        get_beat(d, l); ts[63:32] = d;
        get_beat(d, l); ts[31:0]  = d;
        cnt   = int'(hdr[15:0]);
        exp_w = hdr[20] ? (cnt + 1) / 2 : cnt;
        nw = 0;
        l  = 1'b0;
        while (!l) begin
            get_beat(d, l);
            if (chk_pay) begin
                if (hdr[20]) e = {(2*nw+1 < cnt) ? pr(ts + 64'(2*nw+1)) : 16'h0, pr(ts + 64'(2*nw))};
                else         e = mk(ts + 64'(nw));
                chk(d == e, {tag, " payload"}, d, e);
            end
            nw++;
        end
        if (chk_pay) chk(nw == exp_w, {tag, " R3 word count"}, nw, exp_w);
    endtask

    task automatic t_reset;
        chk(pkt_tvalid == 1'b0, "R1 pkt_tvalid", pkt_tvalid, 0);
        chk(cmd_tready == 1'b1, "R1 cmd_tready", cmd_tready, 1);
        chk(smp_tready == 1'b1, "R1 smp_tready", smp_tready, 1);
    endtask

    task automatic t_wide;
        logic [31:0] h; logic [63:0] ts; int nw; logic [63:0] t0;
        t0 = tidx;
        send_cmd(16'd6, 1'b0, 1'b0, 64'd0);
        read_pkt("R4 wide", 1'b1, h, ts, nw);
        chk(h == 32'h0000_0006, "R3 header", h, 32'h6);
        chk(ts >= t0, "R4 timestamp not before command", ts, t0);
    endtask

    task automatic t_timed;
        logic [31:0] h; logic [63:0] ts; int nw; logic [63:0] st;
        gap_on = 1'b1;
        st = tidx + 64'd150;
        send_cmd(16'd5, 1'b1, 1'b0, st);
        read_pkt("R5 timed", 1'b1, h, ts, nw);
        chk(ts == st, "R5 timestamp equals start", ts, st);
        chk(h == 32'h0001_0005, "R5 header wait set late clear", h, 32'h10005);
        gap_on = 1'b0;
    endtask

    task automatic t_late;
        logic [31:0] h; logic [63:0] ts; int nw;
        send_cmd(16'd3, 1'b1, 1'b0, 64'd4);
        read_pkt("R6 late", 1'b1, h, ts, nw);
        chk(h[18] == 1'b1, "R6 late bit", h[18], 1);
        chk(ts > 64'd4, "R6 immediate capture", ts, 5);
    endtask

    task automatic t_narrow;
        logic [31:0] h; logic [63:0] ts; int nw;
        narrow_sel = 1'b1;
        send_cmd(16'd5, 1'b0, 1'b0, 64'd0);
        read_pkt("R7 narrow odd", 1'b1, h, ts, nw);
        chk(h[20] == 1'b1, "R7 narrow header bit", h[20], 1);
        chk(nw == 3, "R7 odd count words", nw, 3);
        gap_on = 1'b1;
        send_cmd(16'd8, 1'b0, 1'b0, 64'd0);
        read_pkt("R7 narrow even", 1'b1, h, ts, nw);
        gap_on = 1'b0;
        narrow_sel = 1'b0;
    endtask

    task automatic t_stall;
        logic [31:0] h; logic [63:0] ts; int nw; int n0;
        @(posedge clk); #1; pkt_tready = 1'b0;
        send_cmd(16'd4, 1'b0, 1'b0, 64'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(smp_tready == 1'b0, "R8 sample input held during framing", smp_tready, 0);
        n0 = bq_n;
        chk(n0 == rd, "R11 no beat while stalled", n0, rd);
        @(posedge clk); #1; pkt_tready = 1'b1;
        read_pkt("R8 stalled header", 1'b1, h, ts, nw);
    endtask

    task automatic t_overflow;
        logic [31:0] h; logic [63:0] ts; int nw; logic [31:0] d; logic l;
        send_cmd(16'd10, 1'b0, 1'b0, 64'd0);
        get_beat(h, l); get_beat(d, l); get_beat(d, l);
        @(posedge clk); #1; pkt_tready = 1'b0;
        repeat (4) @(posedge clk);
        #1; pkt_tready = 1'b1;
        nw = 0; l = 1'b0;
        while (!l) begin get_beat(d, l); nw++; end
        chk(d == 32'h0, "R9 closing beat zero", d, 0);
        chk(nw < 10, "R9 burst cut short", nw, 10);
        send_cmd(16'd2, 1'b0, 1'b0, 64'd0);
        read_pkt("R9 after overflow", 1'b1, h, ts, nw);
        chk(h[19] == 1'b1, "R9 overflow bit set", h[19], 1);
        send_cmd(16'd2, 1'b0, 1'b0, 64'd0);
        read_pkt("R9 second after", 1'b1, h, ts, nw);
        chk(h[19] == 1'b0, "R9 overflow bit cleared", h[19], 0);
    endtask

    task automatic t_continuous;
        logic [31:0] h; logic [63:0] ts, pts; int nw;
        send_cmd(16'd4, 1'b0, 1'b1, 64'd0);
        read_pkt("R10 cont 0", 1'b1, h, pts, nw);
        chk(h == 32'h0002_0004, "R10 header", h, 32'h20004);
        for (int k = 1; k < 3; k++) begin
            read_pkt("R10 cont k", 1'b1, h, ts, nw);
            chk(ts == pts + 64'd4, "R10 contiguous timestamps", ts, pts + 64'd4);
            pts = ts;
        end
        send_cmd(16'd0, 1'b0, 1'b0, 64'd0);
        repeat (40) @(posedge clk);
        while (rd < bq_n) read_pkt("R10 drain", 1'b1, h, ts, nw);
        repeat (60) @(posedge clk);
        chk(bq_n == rd, "R10 run stopped", bq_n, rd);
    endtask

    task automatic t_zero;
        int n0;
        n0 = bq_n;
        send_cmd(16'd0, 1'b0, 1'b0, 64'd0);
        repeat (40) @(posedge clk);
        chk(bq_n == n0, "R2 zero count gives no packet", bq_n, n0);
        @(negedge clk);
        chk(cmd_tready == 1'b1, "R2 zero command consumed", cmd_tready, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide();
        t_timed();
        t_late();
        t_narrow();
        t_stall();
        t_overflow();
        t_continuous();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule